// File: doc/BRIEF.md
# Lag-Sweep Autocorrelation Engine

The engine holds one vector of signed 16-bit samples in an internal buffer and, on command, computes its autocorrelation for a run of lags starting at lag 0. For every lag it multiplies the vector against a shifted view of the same vector and adds up the products. It then divides the sum by the full vector length, not by the number of overlapping terms. Each normalized result is presented on a valid/ready output together with its lag index.

Software or an upstream block first fills the buffer through a simple write port. It then issues a one-cycle start together with the vector length and the number of lags it wants. The engine stays busy until the consumer has accepted the last lag. Each lag takes one accumulate cycle per overlapping term, then a fixed-length sequential division, then the output handshake.

Top module: `acorr_engine`

## Requirements
- R1: After reset `busy` and `res_valid` are 0.
- R2: A cycle with `wr_en` high stores `wr_data` as sample x[a] at buffer address a = `wr_addr`. Sample index n lives at address n.
- R3: The result for lag k is the sum over n of x[n]·x[n+k], with samples read as two's-complement 16-bit values, divided by the vector length `len` and truncated toward zero.
- R4: Products whose index n+k is `len` or greater count as zero, so any lag k ≥ `len` yields exactly 0.
- R5: A run produces exactly `lags` results, for lags 0, 1, … in increasing order, and `res_lag` carries the lag of the result on `res_data`.
- R6: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_data` and `res_lag` hold their values into the next cycle.
- R7: `busy` rises in the cycle after an accepted start, `res_valid` is only high while `busy` is high, and `busy` falls in the cycle after the last result is accepted.
- R8: A start pulse while `busy` is high is ignored, together with its `len` and `lags` values.
- R9: A start pulse with `len` = 0 or `lags` = 0 is ignored and leaves `busy` low.
- R10: `len` may be any value from 1 to DEPTH and `lags` any value from 1 to LAG_MAX. The 48-bit result does not overflow even for a full-length vector of −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Sample write strobe |
| wr_addr | input | AW (8) | Sample index to write |
| wr_data | input | SAMPLE_W (16) | Signed sample value |
| start | input | 1 | One-cycle run request |
| len | input | LW (9) | Vector length N for the run |
| lags | input | KW (5) | Number of lags K for the run |
| busy | output | 1 | Run in progress |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts result |
| res_data | output | ACC_W (48) | Signed normalized autocorrelation value |
| res_lag | output | KW (5) | Lag index of `res_data` |

## Verification
The timing of a result depends on the data: a lag needs (len − k) accumulate cycles, one cycle to launch the division, 48 division cycles and one capture cycle before `res_valid` rises. The bench therefore predicts no fixed latency for results. It steps on falling edges, takes a value only when `res_valid` and `res_ready` are both high at that point, and so counts the handshake that occurs at the following rising edge. The control timing is fixed and is checked at fixed times. `busy` is sampled one falling edge after the start pulse and one falling edge after the last handshake. Under backpressure, a held result is compared again exactly one cycle later.

// File: rtl/acorr_pkg.sv
package acorr_pkg;

    localparam int DEF_SAMPLE_W = 16;
    localparam int DEF_DEPTH    = 256;
    localparam int DEF_LAG_MAX  = 16;
    localparam int DEF_ACC_W    = 48;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_MAC  = 2'd1,
        S_DIV  = 2'd2,
        S_OUT  = 2'd3
    } eng_state_e;

endpackage

// File: rtl/acorr_buf.sv
module acorr_buf #(
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 256,
    parameter int AW       = 8
) (
    input  logic                       clk,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic signed [SAMPLE_W-1:0] wr_data,
    input  logic [AW-1:0]              rd_a_addr,
    input  logic [AW-1:0]              rd_b_addr,
    output logic signed [SAMPLE_W-1:0] rd_a,
    output logic signed [SAMPLE_W-1:0] rd_b
);

    logic signed [SAMPLE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_a = mem[rd_a_addr];
    assign rd_b = mem[rd_b_addr];

endmodule

// File: rtl/acorr_mac.sv
module acorr_mac #(
    parameter int SAMPLE_W = 16,
    parameter int ACC_W    = 48
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       en,
    input  logic signed [SAMPLE_W-1:0] a,
    input  logic signed [SAMPLE_W-1:0] b,
    output logic signed [ACC_W-1:0]    acc
);

    localparam int PW = 2 * SAMPLE_W;

    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] prod_ext;

    assign prod     = a * b;
    assign prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + prod_ext;
        end
    end

endmodule

// File: rtl/acorr_div.sv
module acorr_div #(
    parameter int ACC_W = 48,
    parameter int DW    = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    go,
    input  logic signed [ACC_W-1:0] dividend,
    input  logic [DW-1:0]           divisor,
    output logic                    done,
    output logic signed [ACC_W-1:0] quotient
);

    localparam int CW = $clog2(ACC_W + 1);

    logic             run;
    logic             neg;
    logic [CW-1:0]    cnt;
    logic [DW-1:0]    rem;
    logic [ACC_W-1:0] q;
    logic [DW:0]      trial;

    assign trial    = {rem, q[ACC_W-1]};
    assign quotient = neg ? -$signed(q) : $signed(q);

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            neg  <= 1'b0;
            cnt  <= '0;
            rem  <= '0;
            q    <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                run <= 1'b1;
                neg <= dividend[ACC_W-1];
                q   <= dividend[ACC_W-1] ? ACC_W'(-dividend) : ACC_W'(dividend);
                rem <= '0;
                cnt <= CW'(ACC_W);
            end else if (run) begin
                if (trial >= {1'b0, divisor}) begin
                    rem <= DW'(trial - {1'b0, divisor});
                    q   <= {q[ACC_W-2:0], 1'b1};
                end else begin
                    rem <= trial[DW-1:0];
                    q   <= {q[ACC_W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/acorr_engine.sv
module acorr_engine
    import acorr_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int DEPTH    = DEF_DEPTH,
    parameter int LAG_MAX  = DEF_LAG_MAX,
    parameter int ACC_W    = DEF_ACC_W,
    localparam int AW      = $clog2(DEPTH),
    localparam int LW      = $clog2(DEPTH + 1),
    localparam int KW      = $clog2(LAG_MAX + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic signed [SAMPLE_W-1:0] wr_data,
    input  logic                       start,
    input  logic [LW-1:0]              len,
    input  logic [KW-1:0]              lags,
    output logic                       busy,
    output logic                       res_valid,
    input  logic                       res_ready,
    output logic signed [ACC_W-1:0]    res_data,
    output logic [KW-1:0]              res_lag
);

    eng_state_e state;

    logic [LW-1:0]              len_q;
    logic [LW-1:0]              n_q;
    logic [KW-1:0]              lags_q;
    logic [KW-1:0]              lag_q;
    logic signed [ACC_W-1:0]    res_q;
    logic [LW:0]                idx_b;
    logic                       in_range;
    logic                       start_ok;
    logic                       last_lag;
    logic signed [SAMPLE_W-1:0] smp_a;
    logic signed [SAMPLE_W-1:0] smp_b;
    logic signed [ACC_W-1:0]    acc;
    logic                       mac_en;
    logic                       mac_clr;
    logic                       div_go;
    logic                       div_done;
    logic signed [ACC_W-1:0]    div_q;

    assign idx_b    = {1'b0, n_q} + {{(LW + 1 - KW){1'b0}}, lag_q};
    assign in_range = idx_b < {1'b0, len_q};
    assign start_ok = start && (len != '0) && (lags != '0);
    assign last_lag = lag_q == KW'(lags_q - 1'b1);
    assign mac_en   = (state == S_MAC) && in_range;
    assign mac_clr  = (state == S_IDLE) || (state == S_OUT);
    assign div_go   = (state == S_MAC) && !in_range;

    acorr_buf #(
        .SAMPLE_W (SAMPLE_W),
        .DEPTH    (DEPTH),
        .AW       (AW)
    ) u_buf (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_a_addr (n_q[AW-1:0]),
        .rd_b_addr (idx_b[AW-1:0]),
        .rd_a      (smp_a),
        .rd_b      (smp_b)
    );

    acorr_mac #(
        .SAMPLE_W (SAMPLE_W),
        .ACC_W    (ACC_W)
    ) u_mac (
        .clk (clk),
        .rst (rst),
        .clr (mac_clr),
        .en  (mac_en),
        .a   (smp_a),
        .b   (smp_b),
        .acc (acc)
    );

    acorr_div #(
        .ACC_W (ACC_W),
        .DW    (LW)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go),
        .dividend (acc),
        .divisor  (len_q),
        .done     (div_done),
        .quotient (div_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            len_q  <= '0;
            lags_q <= '0;
            lag_q  <= '0;
            n_q    <= '0;
            res_q  <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start_ok) begin
                        len_q  <= len;
                        lags_q <= lags;
                        lag_q  <= '0;
                        n_q    <= '0;
                        state  <= S_MAC;
                    end
                end
                S_MAC: begin
                    if (in_range) begin
                        n_q <= n_q + 1'b1;
                    end else begin
                        state <= S_DIV;
                    end
                end
                S_DIV: begin
                    if (div_done) begin
                        res_q <= div_q;
                        state <= S_OUT;
                    end
                end
                S_OUT: begin
                    if (res_ready) begin
                        if (last_lag) begin
                            state <= S_IDLE;
                        end else begin
                            lag_q <= lag_q + 1'b1;
                            n_q   <= '0;
                            state <= S_MAC;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy      = state != S_IDLE;
    assign res_valid = state == S_OUT;
    assign res_data  = res_q;
    assign res_lag   = lag_q;

endmodule

// File: rtl/acorr_engine_chk.sv
module acorr_engine_chk #(
    parameter int LW    = 9,
    parameter int KW    = 5,
    parameter int ACC_W = 48
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic [LW-1:0]           len,
    input logic [KW-1:0]           lags,
    input logic                    busy,
    input logic                    res_valid,
    input logic                    res_ready,
    input logic signed [ACC_W-1:0] res_data,
    input logic [KW-1:0]           res_lag
);

    logic [KW-1:0] seen_lag;
    logic [LW-1:0] run_len;
    logic          good_start;

    assign good_start = start && (len != '0) && (lags != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_lag <= '0;
            run_len  <= '0;
        end else if (!busy && good_start) begin
            seen_lag <= '0;
            run_len  <= len;
        end else if (res_valid && res_ready) begin
            seen_lag <= seen_lag + 1'b1;
        end
    end

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_lag)); // R6

    AST_LAG_SEQUENCE: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> res_lag == seen_lag); // R5

    AST_ZERO_PAST_LEN: assert property (@(posedge clk) disable iff (rst)
        res_valid && (int'(res_lag) >= int'(run_len)) |-> res_data == '0); // R4

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        !busy && good_start |=> busy); // R7

    AST_VALID_INSIDE_BUSY: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> busy); // R7

    AST_BAD_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        !busy && start && !good_start |=> !busy); // R9

    AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (rst)
        busy && start && !res_valid |=> busy); // R8

endmodule

bind acorr_engine acorr_engine_chk #(
    .LW    (LW),
    .KW    (KW),
    .ACC_W (ACC_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .len       (len),
    .lags      (lags),
    .busy      (busy),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_data  (res_data),
    .res_lag   (res_lag)
);

// File: tb/acorr_engine_tb.sv
`timescale 1ns/1ps
module acorr_engine_tb;

    localparam int SW      = 16;
    localparam int DEPTH   = 256;
    localparam int LAG_MAX = 16;
    localparam int ACC_W   = 48;
    localparam int AW      = 8;
    localparam int LW      = 9;
    localparam int KW      = 5;

    logic                    clk = 1'b0;
    logic                    rst;
    logic                    wr_en;
    logic [AW-1:0]           wr_addr;
    logic signed [SW-1:0]    wr_data;
    logic                    start;
    logic [LW-1:0]           len;
    logic [KW-1:0]           lags;
    logic                    busy;
    logic                    res_valid;
    logic                    res_ready;
    logic signed [ACC_W-1:0] res_data;
    logic [KW-1:0]           res_lag;

    int checks = 0;
    int fails  = 0;
    logic signed [SW-1:0] model [DEPTH];

    always #2.5 clk = ~clk;

    acorr_engine u_dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .start     (start),
        .len       (len),
        .lags      (lags),
        .busy      (busy),
        .res_valid (res_valid),
        .res_ready (res_ready),
        .res_data  (res_data),
        .res_lag   (res_lag)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint expect_lag(input int n, input int k);
        longint s = 0;
        for (int i = 0; i + k < n; i++) begin
            s += longint'(model[i]) * longint'(model[i + k]);
        end
        return s / longint'(n);
    endfunction

    task automatic put_sample(input int a, input logic signed [SW-1:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = AW'(a);
        wr_data = v;
        model[a] = v;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic run_case(input int n, input int k, input int stall,
                            input bit disturb, input string vreq);
        longint exp_v [LAG_MAX];
        int     got;
        bit     held;
        longint held_v;
        int     held_l;
        for (int j = 0; j < k; j++) exp_v[j] = expect_lag(n, j);
        @(negedge clk);
        len   = LW'(n);
        lags  = KW'(k);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R7", "busy after start", longint'(busy), 1);
        got  = 0;
        held = 1'b0;
        if (disturb) begin
            start = 1'b1;
            len   = LW'(1);
            lags  = KW'(1);
        end
        while (got < k) begin
            if (held) begin
                check(res_valid == 1'b1, "R6", "valid held", longint'(res_valid), 1);
                check(res_data == held_v && int'(res_lag) == held_l, "R6",
                      "data held", longint'(res_data), held_v);
            end
            held = 1'b0;
            res_ready = ($urandom_range(99) >= stall);
            if (res_valid) begin
                check(int'(res_lag) == got, "R5", "lag order", longint'(res_lag), got);
                check(res_data == exp_v[got], vreq, "lag value", longint'(res_data), exp_v[got]);
                if (res_ready) got++;
                else begin
                    held   = 1'b1;
                    held_v = res_data;
                    held_l = int'(res_lag);
                end
            end
            @(negedge clk);
            start = 1'b0;
        end
        res_ready = 1'b0;
        check(busy == 1'b0, "R7", "busy falls after last", longint'(busy), 0);
        repeat (3) begin
            @(negedge clk);
            check(res_valid == 1'b0 && busy == 1'b0, "R8", "no extra results",
                  longint'(res_valid), 0);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        void'($urandom(32'h5eed_0acc));
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        start = 1'b0; len = '0; lags = '0; res_ready = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && res_valid == 1'b0, "R1", "reset outputs",
              longint'({busy, res_valid}), 0);

        // R2 / R4 directed: x = 1,2,3,4, lags beyond len give 0
        for (int i = 0; i < 4; i++) put_sample(i, 16'(i + 1));
        run_case(4, 6, 0, 1'b0, "R2");

        // R3 negative sum truncated toward zero: x = 3,-5 -> lag1 = -15/2 = -7
        put_sample(0, 16'sd3);
        put_sample(1, -16'sd5);
        run_case(2, 2, 50, 1'b0, "R3");
        run_case(2, 4, 0, 1'b0, "R4");

        // R9 starts with zero length or zero lag count
        @(negedge clk); len = 0; lags = 3; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R9", "len zero ignored", longint'(busy), 0);
        @(negedge clk); len = 4; lags = 0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R9", "lags zero ignored", longint'(busy), 0);

        // R10 full-length extreme magnitude
        for (int i = 0; i < DEPTH; i++) put_sample(i, -16'sd32768);
        run_case(DEPTH, 3, 20, 1'b0, "R10");

        // R8 restart while busy ignored
        for (int i = 0; i < 40; i++) put_sample(i, 16'($urandom_range(65535)));
        run_case(40, 7, 30, 1'b1, "R8");

        // Random lengths, lag counts, samples and backpressure
        for (int r = 0; r < 7; r++) begin
            int n = $urandom_range(DEPTH, 1);
            int k = $urandom_range(LAG_MAX, 1);
            for (int i = 0; i < n; i++) put_sample(i, 16'($urandom_range(65535)));
            run_case(n, k, 25, 1'b0, "R3");
        end
        run_case(5, LAG_MAX, 40, 1'b0, "R4");

        summary();
    end

endmodule